// File: doc/BRIEF.md
# DDR2 Command Bus Monitor

This block watches the command pins of a DDR2 SDRAM from the controller side and drives nothing back onto the bus. On every rising clock edge it combines the clock-enable level from the previous edge with the current one and samples chip select, the three strobes, two bank-address bits and address bit 10. From these it decodes one command. It follows the memory's state: which of the four banks hold an open row, whether the device is powered up, in power-down or in self refresh, and several short timing windows counted in clock cycles.

Whenever the decoded command is not allowed in the state the monitor has tracked, it raises a violation flag for one cycle together with a code naming the rule that failed. The decoded command and the four open-bank flags are registered outputs, so a testbench or an on-chip debug path can follow the bus. Outputs change one clock after the edge that sampled the command. The exit window, the read-after-exit window, the minimum clock-enable hold, the burst length in clocks and the mode-register/precharge busy time are parameters in clock cycles. A window of length T makes a command issued k edges after its start legal when k >= T.

Top module: `ddr2_cmd_monitor`

## Requirements
- R1: With clock enable high on both edges, chip select high decodes as deselect (code 0) whatever the strobes are. Chip select low with RAS#, CAS# and WE# all high decodes as no-operation (code 1).
- R2: With clock enable high on both edges and chip select low, these RAS#/CAS#/WE# patterns decode as follows: LLH refresh (4), LHH activate (7), HLH read (8), HLL write (10), LHL precharge (12). The pattern HHL decodes as illegal (17) and raises violation code 8.
- R3: The LLL pattern is a mode-register write, and the bank bits choose the target. Bank bits 00 give the base register (2) and 01 the extended register (3). Bank bits 1x are illegal (17), violation code 8.
- R4: Address bit 10 high turns read into read with auto-precharge (9), write into write with auto-precharge (11) and precharge into precharge-all (13). Activate sets the addressed bank's open flag. Precharge, read with auto-precharge and write with auto-precharge clear it, and precharge-all clears every flag. Bit n of the bank output is bank n.
- R5: Clock enable falling together with the refresh pattern is self-refresh entry (5). If any bank is open, this raises violation code 2.
- R6: A mode-register write (either target) issued while any bank is open raises violation code 1.
- R7: During the TXSNR-1 edges that follow a self-refresh exit, any command other than deselect or no-operation raises violation code 4.
- R8: A read issued fewer than TXSRD edges after a self-refresh exit raises violation code 5, unless code 4 applies.
- R9: Self-refresh or power-down entry issued while a burst, or the TBUSY-cycle window after a mode-register write or precharge, is still running raises violation code 3.
- R10: A read or write issued within BURST_CYC-1 edges of an earlier read or write raises violation code 6.
- R11: Clock enable changing level after holding the previous level for fewer than TCKE edges raises violation code 7. This code has the highest priority.
- R12: Violation codes are ranked 7, 8, 4, 5, 6, 1, 2, 3, and the highest applicable code is reported. The flag is high exactly when the code is non-zero, and it drops in the next cycle if the next command is legal.
- R13: Reset leaves every bank closed, the decoded command as deselect (0), no violation, the device powered up, and clock enable treated as high for at least TCKE edges.
- R14: A falling clock enable with deselect or no-operation is power-down entry (14). Low on both edges is a hold (16). A rising clock enable with deselect or no-operation is self-refresh exit (6) or power-down exit (15), depending on the tracked state. Any other command on a clock-enable edge is illegal (17), violation code 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable level at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Address bit 10 (auto-precharge / all banks) |
| cmd_o | output | 5 | Decoded command code of the last sampled edge |
| bank_open_o | output | 4 | Per-bank open-row flags |
| viol_o | output | 1 | Violation flag, high for each illegal command |
| viol_code_o | output | 4 | Code of the rule that failed, 0 when none |

## Verification
The bench builds the monitor with TXSNR=4, TXSRD=7, TCKE=3, BURST_CYC=2 and TBUSY=2. These short windows let a single walk through the vector table cover several cases. A self-refresh exit is followed by a command inside the exit window, then by a read that lands after that window has closed but before the read window has. A clock enable held low for only two edges trips the hold rule, while one held for exactly three edges passes. The two-cycle burst and busy windows allow back-to-back column commands and an entry right after a precharge to be tested, and both end within a few vectors.

// File: rtl/ddr2_mon_pkg.sv
package ddr2_mon_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BA_W      = 2;

    typedef enum logic [4:0] {
        CMD_DESEL   = 5'd0,
        CMD_NOP     = 5'd1,
        CMD_MRS     = 5'd2,
        CMD_EMRS    = 5'd3,
        CMD_REF     = 5'd4,
        CMD_SRE     = 5'd5,
        CMD_SRX     = 5'd6,
        CMD_ACT     = 5'd7,
        CMD_RD      = 5'd8,
        CMD_RDA     = 5'd9,
        CMD_WR      = 5'd10,
        CMD_WRA     = 5'd11,
        CMD_PRE     = 5'd12,
        CMD_PREA    = 5'd13,
        CMD_PDE     = 5'd14,
        CMD_PDX     = 5'd15,
        CMD_CKE_LOW = 5'd16,
        CMD_ILLEGAL = 5'd17
    } cmd_e;

    typedef enum logic [3:0] {
        VIO_NONE       = 4'd0,
        VIO_MRS_OPEN   = 4'd1,
        VIO_SRE_OPEN   = 4'd2,
        VIO_ENTRY_BUSY = 4'd3,
        VIO_EXIT_WIN   = 4'd4,
        VIO_READ_EARLY = 4'd5,
        VIO_BURST_CUT  = 4'd6,
        VIO_CKE_WIDTH  = 4'd7,
        VIO_ILLEGAL    = 4'd8
    } vio_e;

    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_DOWN = 2'd1,
        PWR_SELF = 2'd2
    } pwr_e;

    typedef struct packed {
        pwr_e                 pwr;
        logic [NUM_BANKS-1:0] open;
        cmd_e                 cmd;
        vio_e                 vio;
    } mon_state_t;

endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
    import ddr2_mon_pkg::*;
(
    input  logic            cke_prev,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    input  logic            in_self,
    output cmd_e            cmd
);

    logic [2:0] strobes;
    logic       quiet;

    assign strobes = {ras_n, cas_n, we_n};
    assign quiet   = cs_n || (strobes == 3'b111);

    always_comb begin
        cmd = CMD_ILLEGAL;
        case ({cke_prev, cke})
            2'b11: begin
                if (cs_n) begin
                    cmd = CMD_DESEL;
                end else begin
                    case (strobes)
                        3'b111: cmd = CMD_NOP;
                        3'b000: begin
                            if (ba == 2'b00)      cmd = CMD_MRS;
                            else if (ba == 2'b01) cmd = CMD_EMRS;
                            else                  cmd = CMD_ILLEGAL;
                        end
                        3'b001: cmd = CMD_REF;
                        3'b011: cmd = CMD_ACT;
                        3'b101: cmd = a10 ? CMD_RDA  : CMD_RD;
                        3'b100: cmd = a10 ? CMD_WRA  : CMD_WR;
                        3'b010: cmd = a10 ? CMD_PREA : CMD_PRE;
                        default: cmd = CMD_ILLEGAL;
                    endcase
                end
            end
            2'b10: begin
                if (!cs_n && strobes == 3'b001) cmd = CMD_SRE;
                else if (quiet)                 cmd = CMD_PDE;
                else                            cmd = CMD_ILLEGAL;
            end
            2'b01: begin
                if (quiet) cmd = in_self ? CMD_SRX : CMD_PDX;
                else       cmd = CMD_ILLEGAL;
            end
            default: cmd = CMD_CKE_LOW;
        endcase
    end

endmodule

// File: rtl/ddr2_cke_guard.sv
module ddr2_cke_guard #(
    parameter int TCKE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    output logic cke_prev,
    output logic short_hold
);

    localparam int RUN_W = (TCKE > 1) ? $clog2(TCKE + 1) : 1;
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(TCKE);

    typedef struct packed {
        logic             lvl;
        logic [RUN_W-1:0] run;
    } guard_t;

    guard_t g_d, g_q;
    logic   toggle;

    always_comb begin
        toggle   = (cke != g_q.lvl);
        g_d      = g_q;
        g_d.lvl  = cke;
        if (toggle) begin
            g_d.run = RUN_W'(1);
        end else if (g_q.run != RUN_MAX) begin
            g_d.run = g_q.run + RUN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.lvl <= 1'b1;
            g_q.run <= RUN_MAX;
        end else begin
            g_q <= g_d;
        end
    end

    assign cke_prev   = g_q.lvl;
    assign short_hold = toggle && (g_q.run < RUN_MAX);

endmodule

// File: rtl/ddr2_win_timer.sv
module ddr2_win_timer #(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);

    localparam int CNT_W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(LEN - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/ddr2_cmd_monitor.sv
module ddr2_cmd_monitor
    import ddr2_mon_pkg::*;
#(
    parameter int TXSNR     = 16,
    parameter int TXSRD     = 200,
    parameter int TCKE      = 3,
    parameter int BURST_CYC = 2,
    parameter int TBUSY     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic [1:0] ba,
    input  logic       a10,
    output logic [4:0] cmd_o,
    output logic [3:0] bank_open_o,
    output logic       viol_o,
    output logic [3:0] viol_code_o
);

    mon_state_t s_d, s_q;

    cmd_e cmd;
    logic cke_prev;
    logic cke_short;
    logic xsnr_act, xsrd_act, burst_act, busy_act;
    logic is_col, is_entry, is_quiet, is_mode, sets_busy, self_exit;

    ddr2_cke_guard #(.TCKE(TCKE)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cke_prev   (cke_prev),
        .short_hold (cke_short)
    );

    ddr2_cmd_decode u_decode (
        .cke_prev (cke_prev),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ba       (ba),
        .a10      (a10),
        .in_self  (s_q.pwr == PWR_SELF),
        .cmd      (cmd)
    );

    assign is_col    = (cmd == CMD_RD) || (cmd == CMD_RDA) ||
                       (cmd == CMD_WR) || (cmd == CMD_WRA);
    assign is_entry  = (cmd == CMD_SRE) || (cmd == CMD_PDE);
    assign is_quiet  = (cmd == CMD_DESEL) || (cmd == CMD_NOP);
    assign is_mode   = (cmd == CMD_MRS) || (cmd == CMD_EMRS);
    assign sets_busy = is_mode || (cmd == CMD_PRE) || (cmd == CMD_PREA);
    assign self_exit = !cke_prev && cke && (s_q.pwr == PWR_SELF);

    ddr2_win_timer #(.LEN(TXSNR)) u_xsnr (
        .clk (clk), .rst_n (rst_n), .start (self_exit), .active (xsnr_act)
    );

    ddr2_win_timer #(.LEN(TXSRD)) u_xsrd (
        .clk (clk), .rst_n (rst_n), .start (self_exit), .active (xsrd_act)
    );

    ddr2_win_timer #(.LEN(BURST_CYC)) u_burst (
        .clk (clk), .rst_n (rst_n), .start (is_col), .active (burst_act)
    );

    ddr2_win_timer #(.LEN(TBUSY)) u_busy (
        .clk (clk), .rst_n (rst_n), .start (sets_busy), .active (busy_act)
    );

    always_comb begin
        s_d     = s_q;
        s_d.cmd = cmd;

        // ranked rule check, highest first
        if (cke_short) begin
            s_d.vio = VIO_CKE_WIDTH;
        end else if (cmd == CMD_ILLEGAL) begin
            s_d.vio = VIO_ILLEGAL;
        end else if (xsnr_act && !is_quiet) begin
            s_d.vio = VIO_EXIT_WIN;
        end else if (xsrd_act && (cmd == CMD_RD || cmd == CMD_RDA)) begin
            s_d.vio = VIO_READ_EARLY;
        end else if (burst_act && is_col) begin
            s_d.vio = VIO_BURST_CUT;
        end else if (is_mode && (s_q.open != '0)) begin
            s_d.vio = VIO_MRS_OPEN;
        end else if ((cmd == CMD_SRE) && (s_q.open != '0)) begin
            s_d.vio = VIO_SRE_OPEN;
        end else if (is_entry && (burst_act || busy_act)) begin
            s_d.vio = VIO_ENTRY_BUSY;
        end else begin
            s_d.vio = VIO_NONE;
        end

        // bank rows
        case (cmd)
            CMD_ACT:                   s_d.open[ba] = 1'b1;
            CMD_PRE, CMD_RDA, CMD_WRA: s_d.open[ba] = 1'b0;
            CMD_PREA:                  s_d.open     = '0;
            default: ;
        endcase

        // power state follows the clock-enable edges
        if (cke_prev && !cke) begin
            s_d.pwr = (cmd == CMD_SRE) ? PWR_SELF : PWR_DOWN;
        end else if (!cke_prev && cke) begin
            s_d.pwr = PWR_ON;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pwr  <= PWR_ON;
            s_q.open <= '0;
            s_q.cmd  <= CMD_DESEL;
            s_q.vio  <= VIO_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_o       = s_q.cmd;
    assign bank_open_o = s_q.open;
    assign viol_code_o = s_q.vio;
    assign viol_o      = (s_q.vio != VIO_NONE);

endmodule

// File: rtl/ddr2_cmd_monitor_chk.sv
module ddr2_cmd_monitor_chk
    import ddr2_mon_pkg::*;
#(
    parameter int TXSNR     = 16,
    parameter int BURST_CYC = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] cmd_o,
    input logic [3:0] bank_open_o,
    input logic       viol_o,
    input logic [3:0] viol_code_o
);

    // R4
    prea_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PREA) |-> (bank_open_o == 4'b0000));

    // R4
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT) |-> (bank_open_o != 4'b0000));

    // R6
    mrs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == CMD_MRS || cmd_o == CMD_EMRS) && bank_open_o != 4'b0000) |-> viol_o);

    // R5
    sre_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == CMD_SRE) && bank_open_o != 4'b0000) |-> viol_o);

    // R10
    burst_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((BURST_CYC > 1) &&
         (cmd_o >= CMD_RD && cmd_o <= CMD_WRA) &&
         ($past(cmd_o) >= CMD_RD && $past(cmd_o) <= CMD_WRA)) |-> viol_o);

    // R7
    exit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((TXSNR > 1) && $past(cmd_o) == CMD_SRX &&
         cmd_o != CMD_DESEL && cmd_o != CMD_NOP) |-> viol_o);

    // R2
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ILLEGAL) |-> viol_o);

    // R12
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (viol_code_o >= 4'd1 && viol_code_o <= 4'd8));

endmodule

bind ddr2_cmd_monitor ddr2_cmd_monitor_chk #(
    .TXSNR     (TXSNR),
    .BURST_CYC (BURST_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_o       (cmd_o),
    .bank_open_o (bank_open_o),
    .viol_o      (viol_o),
    .viol_code_o (viol_code_o)
);

// File: tb/ddr2_cmd_monitor_tb.sv
module ddr2_cmd_monitor_tb;
    import ddr2_mon_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 41;

    typedef struct packed {
        logic       cke;
        logic       cs_n;
        logic       ras_n;
        logic       cas_n;
        logic       we_n;
        logic [1:0] ba;
        logic       a10;
        logic [4:0] cmd;
        logic [3:0] code;
        logic [3:0] bank;
        logic [7:0] req;
    } vec_t;

    function automatic vec_t mk(int k, int cs, int r, int c, int w, int b,
                                int a, cmd_e ec, int code, int bank, int req);
        vec_t v;
        v.cke   = 1'(k);
        v.cs_n  = 1'(cs);
        v.ras_n = 1'(r);
        v.cas_n = 1'(c);
        v.we_n  = 1'(w);
        v.ba    = 2'(b);
        v.a10   = 1'(a);
        v.cmd   = ec;
        v.code  = 4'(code);
        v.bank  = 4'(bank);
        v.req   = 8'(req);
        return v;
    endfunction

    // cke cs ras cas we ba a10 | cmd code banks req
    localparam vec_t VEC [0:NV-1] = '{
        mk(1,1,1,1,1,0,0, CMD_DESEL,  0, 'b0000,  1), // R1 deselect
        mk(1,0,1,1,1,0,0, CMD_NOP,    0, 'b0000,  1), // R1 nop
        mk(1,0,0,0,0,0,0, CMD_MRS,    0, 'b0000,  3), // R3 base
        mk(1,0,0,0,0,1,0, CMD_EMRS,   0, 'b0000,  3), // R3 extended
        mk(1,0,0,0,0,2,0, CMD_ILLEGAL,8, 'b0000,  3), // R3 reserved target
        mk(1,0,1,1,0,0,0, CMD_ILLEGAL,8, 'b0000,  2), // R2 HHL pattern
        mk(1,0,0,1,1,0,0, CMD_ACT,    0, 'b0001,  4), // R4 open bank 0
        mk(1,0,0,1,1,2,0, CMD_ACT,    0, 'b0101,  4), // R4 open bank 2
        mk(1,0,0,0,0,0,0, CMD_MRS,    1, 'b0101,  6), // R6 banks open
        mk(1,0,1,0,1,0,0, CMD_RD,     0, 'b0101,  2), // R2 read
        mk(1,0,1,0,0,2,0, CMD_WR,     6, 'b0101, 10), // R10 burst cut
        mk(1,0,1,1,1,0,0, CMD_NOP,    0, 'b0101, 12), // R12 flag drops
        mk(1,0,1,0,0,2,1, CMD_WRA,    0, 'b0001,  4), // R4 write autoprecharge
        mk(1,0,1,1,1,0,0, CMD_NOP,    0, 'b0001,  1),
        mk(1,0,0,1,0,0,0, CMD_PRE,    0, 'b0000,  4), // R4 single precharge
        mk(0,0,0,0,1,0,0, CMD_SRE,    3, 'b0000,  9), // R9 entry while busy
        mk(0,1,1,1,1,0,0, CMD_CKE_LOW,0, 'b0000, 14), // R14 low hold
        mk(1,0,1,1,1,0,0, CMD_SRX,    7, 'b0000, 11), // R11 low for 2 edges
        mk(1,0,1,1,1,0,0, CMD_NOP,    0, 'b0000,  7),
        mk(1,0,0,1,1,1,0, CMD_ACT,    4, 'b0010,  7), // R7 inside exit window
        mk(1,1,1,1,1,0,0, CMD_DESEL,  0, 'b0010,  7),
        mk(1,0,1,0,1,1,0, CMD_RD,     5, 'b0010,  8), // R8 read too early
        mk(1,0,1,1,1,0,0, CMD_NOP,    0, 'b0010, 12),
        mk(1,0,1,1,1,0,0, CMD_NOP,    0, 'b0010,  8),
        mk(1,0,1,0,1,1,0, CMD_RD,     0, 'b0010,  8), // R8 read at TXSRD
        mk(1,0,1,1,1,0,0, CMD_NOP,    0, 'b0010, 10),
        mk(1,0,0,1,0,0,1, CMD_PREA,   0, 'b0000,  4), // R4 precharge all
        mk(1,0,1,1,1,0,0, CMD_NOP,    0, 'b0000,  9),
        mk(0,1,1,1,1,0,0, CMD_PDE,    0, 'b0000, 14), // R14 R9 entry after busy
        mk(0,1,1,1,1,0,0, CMD_CKE_LOW,0, 'b0000, 14),
        mk(0,0,1,1,1,0,0, CMD_CKE_LOW,0, 'b0000, 14),
        mk(1,0,1,1,1,0,0, CMD_PDX,    0, 'b0000, 11), // R11 exactly TCKE
        mk(1,0,0,1,1,3,0, CMD_ACT,    0, 'b1000,  4), // R4 bank 3
        mk(1,0,1,1,1,0,0, CMD_NOP,    0, 'b1000,  1),
        mk(1,1,1,1,1,0,0, CMD_DESEL,  0, 'b1000,  1),
        mk(0,0,0,0,1,0,0, CMD_SRE,    2, 'b1000,  5), // R5 bank open
        mk(0,1,1,1,1,0,0, CMD_CKE_LOW,0, 'b1000, 14),
        mk(0,1,1,1,1,0,0, CMD_CKE_LOW,0, 'b1000, 14),
        mk(1,0,0,1,1,0,0, CMD_ILLEGAL,8, 'b1000, 14), // R14 active on rise
        mk(1,0,1,1,1,0,0, CMD_NOP,    0, 'b1000,  7),
        mk(1,1,1,1,1,0,0, CMD_DESEL,  0, 'b1000,  7)
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cke, cs_n, ras_n, cas_n, we_n, a10;
    logic [1:0] ba;
    logic [4:0] cmd_o;
    logic [3:0] bank_open_o;
    logic       viol_o;
    logic [3:0] viol_code_o;

    int n_vec  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr2_cmd_monitor #(
        .TXSNR     (4),
        .TXSRD     (7),
        .TCKE      (3),
        .BURST_CYC (2),
        .TBUSY     (2)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cke         (cke),
        .cs_n        (cs_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .ba          (ba),
        .a10         (a10),
        .cmd_o       (cmd_o),
        .bank_open_o (bank_open_o),
        .viol_o      (viol_o),
        .viol_code_o (viol_code_o)
    );

    task automatic drive(input vec_t v);
        cke   = v.cke;
        cs_n  = v.cs_n;
        ras_n = v.ras_n;
        cas_n = v.cas_n;
        we_n  = v.we_n;
        ba    = v.ba;
        a10   = v.a10;
    endtask

    task automatic expect_out(input int req, input logic [4:0] ecmd,
                              input logic [3:0] ecode, input logic [3:0] ebank);
        n_vec++;
        if (cmd_o !== ecmd || viol_code_o !== ecode ||
            viol_o !== (ecode != 4'd0) || bank_open_o !== ebank) begin
            n_fail++;
            $display("FAIL R%0d: cmd=%0d code=%0d viol=%0b banks=%b expected cmd=%0d code=%0d viol=%0b banks=%b",
                     req, cmd_o, viol_code_o, viol_o, bank_open_o,
                     ecmd, ecode, (ecode != 4'd0), ebank);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(mk(1,1,1,1,1,0,0, CMD_DESEL, 0, 0, 0));
        repeat (3) @(negedge clk);
        // R13 reset state
        expect_out(13, CMD_DESEL, 4'd0, 4'b0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            expect_out(int'(VEC[i].req), VEC[i].cmd, VEC[i].code, VEC[i].bank);
        end

        // let the exit window from the last clock-enable rise close
        drive(mk(1,0,1,1,1,0,0, CMD_NOP, 0, 0, 0));
        @(negedge clk);
        expect_out(1, CMD_NOP, 4'd0, 4'b1000);

        // R4 open a second bank, then reset clears everything (R13)
        drive(mk(1,0,0,1,1,1,0, CMD_ACT, 0, 0, 0));
        @(negedge clk);
        expect_out(4, CMD_ACT, 4'd0, 4'b1010);

        rst_n = 1'b0;
        drive(mk(1,1,1,1,1,0,0, CMD_DESEL, 0, 0, 0));
        @(negedge clk);
        expect_out(13, CMD_DESEL, 4'd0, 4'b0000);

        // R13 clock enable counts as held after reset: immediate drop is clean
        rst_n = 1'b1;
        drive(mk(0,1,1,1,1,0,0, CMD_PDE, 0, 0, 0));
        @(negedge clk);
        expect_out(13, CMD_PDE, 4'd0, 4'b0000);

        // R11 low for a single edge is too short
        drive(mk(1,0,1,1,1,0,0, CMD_PDX, 0, 0, 0));
        @(negedge clk);
        expect_out(11, CMD_PDX, 4'd7, 4'b0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule